// File: doc/BRIEF.md
# MDIO Management Master with Single-Command Register

This block drives one Clause 22 management transaction at a time toward an external PHY. Software sees three word registers on a small read/write port: a command register, a data register and a read-status register. To write a PHY register, software checks that the busy flag is clear, loads the 16-bit value into the data register and then writes a command word with the start flag set. To read, software writes a command word with the start and read flags set, polls until the start flag drops, and then finds the value in the upper half of the data register.

The block generates MDC by dividing the system clock. It shifts the frame out on the tri-state pair mdio_o/mdio_oe and samples mdio_i. The start flag acts as the busy indication and clears by itself when the frame is complete. A read that gets no answer from any PHY is reported through bit 0 of the status register.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low, and the command, data and status registers read as zero.
- R2: The command register sits at address 0. Writing it while idle with bit 20 set starts a frame. Bit 17 set selects read; otherwise the operation is a write. The PHY address is taken from bits 12:8 and the register address from bits 4:0. On readback, bit 20 is 1 while the frame runs and 0 once it ends. Bit 17 (read) or bit 16 (write) shows the last accepted operation, and the address fields are returned in the same positions.
- R3: The frame is sent MSB first and contains, in order: 32 ones, start code 01, opcode 10 for read or 01 for write, the 5-bit PHY address, the 5-bit register address, turnaround 10 on a write, and 16 data bits. On a write, the data bits are the low half of the data register as it stood when the command was accepted.
- R4: While a frame runs, MDC toggles every MDC_HALF_DIV system clocks. It starts low, and mdio_o changes only in the system clock at which MDC falls. The master samples mdio_i where MDC rises.
- R5: On a read, mdio_oe stays high from the first preamble bit through the register address and is low from the first turnaround bit to the end of the frame. On a write, mdio_oe is high for the whole frame.
- R6: The data register sits at address 1. Writes change only its low 16 bits. When a read frame ends, the 16 sampled bits appear in bits 31:16, and the low half keeps its value.
- R7: The status register sits at address 2. When a read frame ends, bit 0 takes the value sampled on the second turnaround bit (1 means no PHY answered). Write frames leave bit 0 unchanged.
- R8: A command written while a frame is in progress is ignored. The running frame and the command readback fields are unaffected.
- R9: A command write with bit 20 clear starts nothing and leaves the command fields unchanged.
- R10: A frame spans exactly 64 MDC periods. Busy clears at the last falling edge of MDC, and MDC stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 data, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Drive enable for the MDIO line |
| mdio_i | input | 1 | Serial data in from the MDIO line |

## Verification
Frames are tried as writes and reads with different PHY and register addresses, including the all-ones field values, and with data words whose set bits sit at both ends. A wrong field order or a wrong shift direction therefore shows up on the line. Reads are run both with a responding PHY and with none. This separates sampled data from the idle pull-up level, and shows that the no-response flag is set and later cleared. A command written in the middle of a frame, a command written without the start bit, and a write frame run after a failed read check, respectively, that the running frame is left alone, that nothing starts, and that the status bit survives.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS   = 64;
  localparam int TA_FIRST_BIT = 46;
  localparam int TA_LAST_BIT  = 47;
  localparam int DATA_FIRST   = 48;
  localparam int BIT_CNT_W    = $clog2(FRAME_BITS);

  localparam int CMD_GO_POS   = 20;
  localparam int CMD_RD_POS   = 17;
  localparam int CMD_PHY_LSB  = 8;
  localparam int CMD_REG_LSB  = 0;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regad;
  } mgmt_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c,
                                                        input logic [15:0] wd);
    return {{32{1'b1}}, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad,
            (c.rd ? 2'b11 : 2'b10), (c.rd ? 16'hFFFF : wd)};
  endfunction
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          terminal;

  assign terminal  = run && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_tick = terminal && !mdc_q;
  assign fall_tick = terminal &&  mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (terminal) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  mgmt_cmd_t       cmd,
  input  logic [15:0]     wdata,
  input  logic            rise_tick,
  input  logic            fall_tick,
  input  logic            mdio_i,
  output logic            busy,
  output logic            mdio_o,
  output logic            mdio_oe,
  output logic            done_rd,
  output logic [15:0]     rd_word,
  output logic            ta_high
);
  logic [FRAME_BITS-1:0] sreg_q, sreg_d;
  logic [BIT_CNT_W-1:0]  bit_q, bit_d;
  logic                  busy_q, busy_d, rd_q, rd_d, ta_q, ta_d;
  logic [15:0]           rsh_q, rsh_d;
  logic                  last_bit;

  assign last_bit = (bit_q == BIT_CNT_W'(FRAME_BITS - 1));

  always_comb begin
    sreg_d  = sreg_q;
    bit_d   = bit_q;
    busy_d  = busy_q;
    rd_d    = rd_q;
    ta_d    = ta_q;
    rsh_d   = rsh_q;
    done_rd = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      bit_d  = '0;
      rd_d   = cmd.rd;
      sreg_d = build_frame(cmd, wdata);
    end else if (busy_q) begin
      if (rise_tick && rd_q) begin
        if (bit_q == BIT_CNT_W'(TA_LAST_BIT)) ta_d = mdio_i;
        if (bit_q >= BIT_CNT_W'(DATA_FIRST))  rsh_d = {rsh_q[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_bit) begin
          busy_d  = 1'b0;
          done_rd = rd_q;
        end else begin
          bit_d  = bit_q + 1'b1;
          sreg_d = {sreg_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      ta_q   <= 1'b0;
      rsh_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      ta_q   <= ta_d;
      rsh_q  <= rsh_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sreg_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && (!rd_q || (bit_q < BIT_CNT_W'(TA_FIRST_BIT)));
  assign rd_word = rsh_q;
  assign ta_high = ta_q;

  // R4: the line only moves where MDC falls
  a_r4_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !fall_tick |=> $stable(mdio_o));
  // R10: a frame ends only after its last bit
  a_r10_end_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bit_q) == BIT_CNT_W'(FRAME_BITS - 1));
  // R8: a new frame is never loaded over a running one
  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        rst_sync_n;
  logic        busy, rise_tick, fall_tick, done_rd, ta_high, accept;
  logic [15:0] rd_word;
  mgmt_cmd_t   cmd_q, cmd_d, new_cmd;
  logic [1:0]  op_q, op_d;
  logic [15:0] wdat_q, wdat_d, rdat_q, rdat_d;
  logic        nores_q, nores_d;
  logic        unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:21], reg_wdata[19:18]};

  mdio_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  mdio_mdc_gen #(.HALF_DIV(MDC_HALF_DIV)) u_mdc_gen (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick));

  assign new_cmd.rd    = reg_wdata[CMD_RD_POS];
  assign new_cmd.phy   = reg_wdata[CMD_PHY_LSB +: 5];
  assign new_cmd.regad = reg_wdata[CMD_REG_LSB +: 5];
  assign accept = reg_we && (reg_addr == SEL_CMD) && reg_wdata[CMD_GO_POS] && !busy;

  mdio_frame_engine u_engine (
    .clk(clk), .rst_n(rst_sync_n), .start(accept), .cmd(new_cmd), .wdata(wdat_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i), .busy(busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_rd(done_rd), .rd_word(rd_word),
    .ta_high(ta_high));

  always_comb begin
    cmd_d   = cmd_q;
    op_d    = op_q;
    wdat_d  = wdat_q;
    rdat_d  = rdat_q;
    nores_d = nores_q;
    if (accept) begin
      cmd_d = new_cmd;
      op_d  = {new_cmd.rd, !new_cmd.rd};
    end
    if (reg_we && (reg_addr == SEL_DATA)) wdat_d = reg_wdata[15:0];
    if (done_rd) begin
      rdat_d  = rd_word;
      nores_d = ta_high;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q   <= '0;
      op_q    <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      nores_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      op_q    <= op_d;
      wdat_q  <= wdat_d;
      rdat_q  <= rdat_d;
      nores_q <= nores_d;
    end
  end

  always_comb begin
    case (reg_addr)
      SEL_CMD:  reg_rdata = {11'd0, busy, 2'd0, op_q, 3'd0, cmd_q.phy, 3'd0, cmd_q.regad};
      SEL_DATA: reg_rdata = {rdat_q, wdat_q};
      SEL_STAT: reg_rdata = {31'd0, nores_q};
      default:  reg_rdata = 32'd0;
    endcase
  end

  // R1 R10: idle means a quiet management line
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> !mdc && !mdio_oe);
  // R8: commands during a frame leave the fields alone
  a_r8_cmd_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy && reg_we && (reg_addr == SEL_CMD) |=> $stable(cmd_q) && $stable(op_q));
  // R7: write frames never touch the status bit
  a_r7_status_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(busy && fall_tick) |=> $stable(nores_q));
endmodule

// File: tb/mdio_cmd_master_bench.sv
module mdio_cmd_master_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n, reg_we, mdc, mdio_o, mdio_oe, mdio_i;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int checks = 0, errors = 0, rises = 0;

  always #5 clk = ~clk;

  mdio_cmd_master #(.MDC_HALF_DIV(HALF)) u_mdio_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // behavioural PHY and reference state
  logic        phy_en;
  logic [15:0] phy_val;
  logic        m_busy, m_mdc, m_rd, m_ta;
  int          m_cnt, m_bit;
  logic [63:0] m_frame;
  logic [15:0] m_rsh, m_wdata;

  always_comb begin
    if (mdio_oe)                      mdio_i = mdio_o;
    else if (phy_en && m_bit == 47)   mdio_i = 1'b0;
    else if (phy_en && m_bit >= 48)   mdio_i = phy_val[63 - m_bit];
    else                              mdio_i = 1'b1;
  end

  always @(posedge mdc) rises++;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_mdc = 0; m_rd = 0; m_ta = 0; m_cnt = 0; m_bit = 0;
      m_frame = '0; m_rsh = '0; m_wdata = '0;
    end else if (m_busy) begin
      if (m_cnt == HALF - 1) begin
        m_cnt = 0;
        if (!m_mdc) begin
          m_mdc = 1;
          if (m_rd && m_bit == 47) m_ta = mdio_i;
          if (m_rd && m_bit >= 48) m_rsh = {m_rsh[14:0], mdio_i};
        end else begin
          m_mdc = 0;
          if (m_bit == 63) m_busy = 0;
          else m_bit++;
        end
      end else m_cnt++;
      if (reg_we && reg_addr == 2'd1) m_wdata = reg_wdata[15:0];
    end else begin
      if (reg_we && reg_addr == 2'd0 && reg_wdata[20]) begin
        m_busy = 1; m_bit = 0; m_cnt = 0; m_rd = reg_wdata[17];
        m_frame = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), reg_wdata[12:8],
                   reg_wdata[4:0], (m_rd ? 2'b11 : 2'b10), (m_rd ? 16'hFFFF : m_wdata)};
      end
      if (reg_we && reg_addr == 2'd1) m_wdata = reg_wdata[15:0];
    end
  end

  // R3 R4 R5: line compared with the reference every clock
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_oe;
      exp_oe = m_busy && (!m_rd || m_bit < 46);
      checks++;
      if (mdc !== m_mdc || mdio_oe !== exp_oe || (exp_oe && mdio_o !== m_frame[63 - m_bit])) begin
        errors++;
        $display("FAIL R3 R4 R5 line act mdc=%b oe=%b o=%b exp mdc=%b oe=%b o=%b bit=%0d",
                 mdc, mdio_oe, mdio_o, m_mdc, exp_oe, m_frame[63 - m_bit], m_bit);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd0, v);
      if (!v[20]) break;
    end
  endtask

  logic [31:0] v;

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; phy_en = 0; phy_val = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (5) @(posedge clk);
    rd(2'd0, v); chk("R1 cmd reg", v, 32'h0);
    rd(2'd1, v); chk("R1 data reg", v, 32'h0);
    rd(2'd2, v); chk("R1 status reg", v, 32'h0);
    chk("R1 mdc/oe", {30'd0, mdc, mdio_oe}, 32'h0);

    wr(2'd1, 32'hFFFF_A5C3);
    rd(2'd1, v); chk("R6 upper not writable", v, 32'h0000_A5C3);
    rises = 0;
    wr(2'd0, 32'h0011_130A);
    rd(2'd0, v); chk("R2 busy readback", v, 32'h0011_130A);
    repeat (40) @(posedge clk);
    wr(2'd0, 32'h0012_0104);
    rd(2'd0, v); chk("R8 command ignored", v, 32'h0011_130A);
    wait_idle();
    rd(2'd0, v); chk("R2 start cleared", v, 32'h0001_130A);
    chk("R10 mdc periods", rises, 64);
    chk("R10 idle line", {30'd0, mdc, mdio_oe}, 32'h0);

    phy_en = 1; phy_val = 16'hBEEF;
    wr(2'd0, 32'h0012_0203);
    rd(2'd0, v); chk("R2 read busy", v, 32'h0012_0203);
    wait_idle();
    rd(2'd1, v); chk("R6 read data", v, 32'hBEEF_A5C3);
    rd(2'd2, v); chk("R7 answered", v, 32'h0);

    phy_en = 0;
    wr(2'd0, 32'h0012_1F1F);
    wait_idle();
    rd(2'd1, v); chk("R6 no-PHY data", v, 32'hFFFF_A5C3);
    rd(2'd2, v); chk("R7 no answer", v, 32'h1);

    wr(2'd1, 32'hDEAD_1234);
    rd(2'd1, v); chk("R6 low half write", v, 32'hFFFF_1234);
    wr(2'd0, 32'h0011_0000);
    wait_idle();
    rd(2'd2, v); chk("R7 write keeps status", v, 32'h1);

    phy_en = 1; phy_val = 16'h8001;
    wr(2'd0, 32'h0012_1500);
    wait_idle();
    rd(2'd1, v); chk("R6 edge bits", v, 32'h8001_1234);
    rd(2'd2, v); chk("R7 cleared by answer", v, 32'h0);

    rises = 0;
    wr(2'd0, 32'h0002_0505);
    repeat (20) @(posedge clk);
    rd(2'd0, v); chk("R9 no start", v, 32'h0002_1500);
    chk("R9 no mdc", rises, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule